// File: doc/BRIEF.md
# Sleep-Mode Bus and Local Wake Qualifier

This block sits between the sampled inputs of a single-wire bus transceiver and its mode controller. While the device sleeps it watches two active-high levels: one that is set while the bus is dominant, and one that is set while the local wake pin is pulled low. It turns qualifying activity on either into a one-cycle request pulse that the mode controller uses to leave sleep.

A bus request needs the whole dominant episode: entry into dominant, a dominant stretch longer than the bus filter time, and the return to recessive. The pulse is issued on the return. A local request needs entry into the low level and a low stretch longer than the local filter time. The pulse is issued while the pin is still low. If sleep begins while the local pin is already low, the pin must stay high for longer than a re-arm time before a new low can count. Whenever the bus is dominant during sleep, a receiver-activate output is raised. All times are parameters in clock cycles, and both inputs pass through a two-flop synchroniser first.

Top module: `bus_wake_detect`

## Requirements
- R1: While `sleep_i` is high, `rx_on_o` follows `bus_dom_i` with a latency of two clock edges, because the input passes through a two-flop synchroniser.
- R2: While sleeping, a dominant run of more than `BUS_FILT` cycles that began with a recessive-to-dominant change gives exactly one `bus_wake_o` pulse. The pulse comes two clock edges after `bus_dom_i` returns low.
- R3: A dominant run of `BUS_FILT` cycles or fewer gives no pulse and restarts the count. Short runs split by even one recessive cycle do not add up.
- R4: A bus that is already dominant when sleep starts has no recessive-to-dominant change, so it gives no bus pulse however long it stays dominant.
- R5: While sleeping, a high-to-low change of the local pin followed by a low run of more than `LOC_FILT` cycles gives a `loc_wake_o` pulse. The pulse is `LOC_FILT`+2 clock edges after `loc_low_i` rises, so the pin is still low. A run of exactly `LOC_FILT` cycles gives none.
- R6: Each qualifying local low run gives one pulse only, however long the pin stays low.
- R7: If `loc_low_i` is high when sleep starts, a local request is only accepted after the pin has been high for more than `REARM` consecutive synchronised cycles. A shorter high gap followed by a long low gives no pulse.
- R8: While `sleep_i` is low, all outputs stay low. Clearing `sleep_i` part-way through an episode discards it.
- R9: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | High while the device is in sleep |
| bus_dom_i | input | 1 | High while the bus level is dominant (asynchronous) |
| loc_low_i | input | 1 | High while the local wake pin is low (asynchronous) |
| bus_wake_o | output | 1 | One-cycle qualified bus wake request |
| loc_wake_o | output | 1 | One-cycle qualified local wake request |
| rx_on_o | output | 1 | Receiver activate, high while sleeping with the bus dominant |

## Verification
The bus path is tried with dominant runs just below, at and just above the filter time. It is also tried with two sub-threshold runs split by a single recessive cycle, which separates a restarting counter from an accumulating one, and with a bus that is already dominant when sleep starts, which shows whether the entry edge is required. The local path is tried with low runs on either side of its filter time and with a very long hold, which shows a single pulse against a repeating one. For the re-arm rule, sleep is entered with the pin low and then high gaps of `REARM` and `REARM`+1 cycles are applied. Random lengths spread around every threshold are mixed in. Sleep is also dropped in the middle of an episode, and exact pulse cycles are checked against the synchroniser latency.

// File: rtl/bus_wake_detect.sv
module bus_wake_detect #(
  parameter int BUS_FILT = 100,
  parameter int LOC_FILT = 100,
  parameter int REARM    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic bus_dom_i,
  input  logic loc_low_i,
  output logic bus_wake_o,
  output logic loc_wake_o,
  output logic rx_on_o
);
  localparam int BW = $clog2(BUS_FILT + 2);
  localparam int LW = $clog2(LOC_FILT + 1);
  localparam int RW = $clog2(REARM + 1);
  localparam logic [BW-1:0] B_TH  = BW'(BUS_FILT);
  localparam logic [BW-1:0] B_SAT = BW'(BUS_FILT + 1);
  localparam logic [LW-1:0] L_TH  = LW'(LOC_FILT);
  localparam logic [RW-1:0] R_TH  = RW'(REARM);

  logic [1:0]    bus_sy, loc_sy;
  logic          bus_s, loc_s, bus_q, loc_q;
  logic          bus_arm, loc_arm, loc_blk;
  logic [BW-1:0] bus_cnt;
  logic [LW-1:0] loc_cnt;
  logic [RW-1:0] hi_cnt;

  assign bus_s = bus_sy[1];
  assign loc_s = loc_sy[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_sy <= '0;
      loc_sy <= '0;
      bus_q  <= 1'b0;
      loc_q  <= 1'b0;
    end else begin
      bus_sy <= {bus_sy[0], bus_dom_i};
      loc_sy <= {loc_sy[0], loc_low_i};
      bus_q  <= bus_s;
      loc_q  <= loc_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_arm <= 1'b0;
      bus_cnt <= '0;
    end else if (!sleep_i) begin
      bus_arm <= 1'b0;
      bus_cnt <= '0;
    end else if (bus_s && !bus_q) begin
      bus_arm <= 1'b1;
      bus_cnt <= BW'(1);
    end else if (bus_s && bus_arm) begin
      if (bus_cnt != B_SAT) bus_cnt <= bus_cnt + BW'(1);
    end else begin
      bus_arm <= 1'b0;
      bus_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_blk <= 1'b0;
      hi_cnt  <= '0;
    end else if (!sleep_i) begin
      loc_blk <= loc_s;
      hi_cnt  <= '0;
    end else if (loc_blk) begin
      if (loc_s) begin
        hi_cnt <= '0;
      end else if (hi_cnt == R_TH) begin
        loc_blk <= 1'b0;
        hi_cnt  <= '0;
      end else begin
        hi_cnt <= hi_cnt + RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_arm <= 1'b0;
      loc_cnt <= '0;
    end else if (!sleep_i) begin
      loc_arm <= 1'b0;
      loc_cnt <= '0;
    end else if (loc_s && !loc_q && !loc_blk) begin
      loc_arm <= 1'b1;
      loc_cnt <= LW'(1);
    end else if (loc_s && loc_arm) begin
      if (loc_cnt == L_TH) loc_arm <= 1'b0;
      else                 loc_cnt <= loc_cnt + LW'(1);
    end else begin
      loc_arm <= 1'b0;
      loc_cnt <= '0;
    end
  end

  assign bus_wake_o = sleep_i && bus_arm && bus_q && !bus_s && (bus_cnt > B_TH);
  assign loc_wake_o = sleep_i && loc_arm && loc_s && (loc_cnt == L_TH);
  assign rx_on_o    = sleep_i && bus_s;
endmodule

module bus_wake_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_i,
  input logic bus_wake_o,
  input logic loc_wake_o,
  input logic rx_on_o
);
  p_bus_needs_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wake_o |-> sleep_i);
  p_loc_needs_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wake_o |-> sleep_i);
  p_rx_quiet_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |-> !rx_on_o);
  p_bus_on_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wake_o |-> (!rx_on_o && $past(rx_on_o)));
  p_bus_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wake_o |=> !bus_wake_o);
  p_loc_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wake_o |=> !loc_wake_o);
endmodule

bind bus_wake_detect bus_wake_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
  .bus_wake_o(bus_wake_o), .loc_wake_o(loc_wake_o), .rx_on_o(rx_on_o)
);

// File: tb/tb_bus_wake_detect.sv
module tb_bus_wake_detect;
  localparam int BF = 12;
  localparam int LF = 10;
  localparam int RA = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_i = 1'b0, bus_dom_i = 1'b0, loc_low_i = 1'b0;
  logic bus_wake_o, loc_wake_o, rx_on_o;

  int checks = 0, fails = 0;
  int cyc = 0, nb = 0, nl = 0, bcyc = -1, lcyc = -1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_wake_detect #(.BUS_FILT(BF), .LOC_FILT(LF), .REARM(RA)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .bus_dom_i(bus_dom_i),
    .loc_low_i(loc_low_i), .bus_wake_o(bus_wake_o), .loc_wake_o(loc_wake_o),
    .rx_on_o(rx_on_o)
  );

  initial forever begin
    @(posedge clk); #1;
    cyc++;
    if (bus_wake_o) begin nb++; bcyc = cyc; end
    if (loc_wake_o) begin nl++; lcyc = cyc; end
  end

  function automatic int exp_bus(int len);
    return (len > BF) ? 1 : 0;
  endfunction
  function automatic int exp_loc(int len);
    return (len > LF) ? 1 : 0;
  endfunction
  function automatic int exp_rearm(int gap);
    return (gap > RA) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_ep(int len, string req);
    int b0 = nb;
    @(negedge clk) bus_dom_i = 1'b1;
    wait_n(len);
    bus_dom_i = 1'b0;
    wait_n(6);
    chk(req, nb - b0, exp_bus(len));
  endtask

  task automatic loc_ep(int len, string req);
    int l0 = nl;
    @(negedge clk) loc_low_i = 1'b1;
    wait_n(len);
    loc_low_i = 1'b0;
    wait_n(RA + 6);
    chk(req, nl - l0, exp_loc(len));
  endtask

  task automatic rearm_ep(int gap, string req);
    int l0;
    @(negedge clk) sleep_i = 1'b0; loc_low_i = 1'b1;
    wait_n(4);
    sleep_i = 1'b1;
    wait_n(4);
    l0 = nl;
    loc_low_i = 1'b0;
    wait_n(gap);
    loc_low_i = 1'b1;
    wait_n(2 * LF);
    loc_low_i = 1'b0;
    wait_n(RA + 6);
    chk(req, nl - l0, exp_rearm(gap));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int rel, b0, l0;
    void'($urandom(32'd20240611));
    wait_n(3);
    chk("R9 reset bus", int'(bus_wake_o), 0);
    chk("R9 reset loc", int'(loc_wake_o), 0);
    chk("R9 reset rx", int'(rx_on_o), 0);
    rst_n = 1'b1;
    wait_n(3);
    chk("R9 post-reset pulses", nb + nl, 0);

    sleep_i = 1'b1;
    wait_n(4);
    // R1 latency
    @(negedge clk) bus_dom_i = 1'b1;
    @(posedge clk); #2 chk("R1 rx after one edge", int'(rx_on_o), 0);
    @(posedge clk); #2 chk("R1 rx after two edges", int'(rx_on_o), 1);
    wait_n(BF + 2);
    rel = cyc;
    bus_dom_i = 1'b0;
    @(posedge clk); #2 chk("R1 rx holds one edge", int'(rx_on_o), 1);
    @(posedge clk); #2 chk("R1 rx clears", int'(rx_on_o), 0);
    wait_n(4);
    chk("R2 bus pulse cycle", bcyc - rel, 2);
    chk("R2 bus pulse count", nb, 1);

    bus_ep(BF, "R3 run at filter");
    bus_ep(BF + 1, "R2 run just above filter");
    bus_ep(BF - 1, "R3 run below filter");

    b0 = nb;
    @(negedge clk) bus_dom_i = 1'b1;
    wait_n(BF);
    bus_dom_i = 1'b0;
    @(negedge clk) bus_dom_i = 1'b1;
    wait_n(BF);
    bus_dom_i = 1'b0;
    wait_n(6);
    chk("R3 split runs do not add", nb - b0, 0);

    b0 = nb;
    @(negedge clk) sleep_i = 1'b0; bus_dom_i = 1'b1;
    wait_n(4);
    sleep_i = 1'b1;
    wait_n(3 * BF);
    bus_dom_i = 1'b0;
    wait_n(6);
    chk("R4 dominant at sleep entry", nb - b0, 0);

    l0 = nl;
    @(negedge clk) loc_low_i = 1'b1;
    rel = cyc;
    wait_n(LF + 4);
    loc_low_i = 1'b0;
    wait_n(RA + 6);
    chk("R5 local pulse cycle", lcyc - rel, LF + 2);
    chk("R5 local pulse count", nl - l0, 1);
    loc_ep(LF, "R5 low at filter");
    loc_ep(LF + 1, "R5 low just above filter");
    loc_ep(5 * LF, "R6 long low single pulse");

    rearm_ep(RA, "R7 gap at rearm");
    rearm_ep(RA + 1, "R7 gap above rearm");
    rearm_ep(1, "R7 short gap");

    b0 = nb; l0 = nl;
    @(negedge clk) sleep_i = 1'b0;
    bus_dom_i = 1'b1; loc_low_i = 1'b1;
    @(posedge clk); @(posedge clk); #2 chk("R8 rx low awake", int'(rx_on_o), 0);
    wait_n(3 * BF + 3 * LF);
    bus_dom_i = 1'b0; loc_low_i = 1'b0;
    wait_n(RA + 6);
    chk("R8 no pulses awake", (nb - b0) + (nl - l0), 0);

    @(negedge clk) sleep_i = 1'b1;
    wait_n(RA + 4);
    b0 = nb;
    bus_dom_i = 1'b1;
    wait_n(2 * BF);
    sleep_i = 1'b0;
    wait_n(2);
    bus_dom_i = 1'b0;
    wait_n(6);
    chk("R8 sleep drop discards bus", nb - b0, 0);
    @(negedge clk) sleep_i = 1'b1;
    wait_n(4);

    for (int i = 0; i < 40; i++) begin
      int k = int'($urandom % 3);
      if (k == 0)      bus_ep(BF - 3 + int'($urandom % 7), "R2 random bus run");
      else if (k == 1) loc_ep(LF - 3 + int'($urandom % 7), "R5 random local run");
      else             rearm_ep(RA - 2 + int'($urandom % 5), "R7 random rearm gap");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule